// File: doc/BRIEF.md
# SPI Receive Status and Overrun Controller

This block is the CPU-facing receive status logic of a serial peripheral. A shift register outside the block delivers each completed byte with a one-cycle strobe. The block decides whether to keep or drop that byte. It holds the receive data register and two status flags: one for "receive buffer full" and one for "overrun". It also produces one interrupt request for each flag.

Software clears the flags with a two-step read. First it reads the status register. That read arms a clear for each flag that was set at that moment. A later read of the data register then clears only the armed flags. A flag that becomes set between the two reads stays set. While the overrun flag is set, every incoming byte is thrown away, and the buffer-full flag does not rise again until the overrun is serviced.

Top module: `spi_rx_status`

## Requirements
- R1: After reset, the buffer-full flag, the overrun flag, both interrupt requests and the data register are all 0 (data 0x00).
- R2: A byte strobe while both flags are clear sets the buffer-full flag and loads the byte into the data register. Both changes are visible in the cycle after the strobe.
- R3: A byte strobe while the buffer-full flag is set and the overrun flag is clear sets the overrun flag. The byte is discarded and the data register keeps its old contents.
- R4: The buffer-full flag clears only on a data read that follows a status read made while that flag was set. A data read with no such armed status read, or a status read alone, leaves the flag unchanged.
- R5: The overrun flag clears on a data read that follows a status read made while the overrun flag was set.
- R6: A flag that becomes set after the status read is not cleared by the next data read. An overrun arising between the two reads survives the data read, while the buffer-full flag armed earlier still clears.
- R7: While the overrun flag is set, a byte strobe does not set the buffer-full flag and does not change the data register.
- R8: A byte strobe in the same cycle as a data read that clears the buffer-full flag counts as arriving after the clear. The byte is loaded, buffer-full stays set, and no overrun results.
- R9: The receive interrupt request equals buffer-full AND the receive interrupt enable. The error interrupt request equals overrun AND the error interrupt enable. Both requests appear in the same cycle as the flag (default build).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_strobe_i | input | 1 | One-cycle pulse: a received byte is ready |
| rx_byte_i | input | DATA_W | Received byte from the shift register |
| rd_stat_i | input | 1 | Bus read strobe of the status register |
| rd_data_i | input | 1 | Bus read strobe of the data register |
| rx_ie_i | input | 1 | Receive interrupt enable |
| err_ie_i | input | 1 | Error (overrun) interrupt enable |
| rx_full_o | output | 1 | Buffer-full flag |
| ovr_o | output | 1 | Overrun flag |
| data_o | output | DATA_W | Receive data register |
| rx_irq_o | output | 1 | Receive interrupt request |
| err_irq_o | output | 1 | Error interrupt request |

## Verification
All flag and data results are registered. A strobe or read strobe presented before clock edge k therefore shows up at the outputs right after edge k, and the interrupt requests follow the flags combinationally in the same cycle.

The bench drives each stimulus on a falling edge and holds it through the next rising edge. It then advances its reference model at that rising edge and compares at the following falling edge, so every check lands exactly one cycle after its stimulus. The read-window and same-cycle cases are driven as directed sequences. Random traffic is compared every cycle.

// File: rtl/spi_rxs_pkg.sv
package spi_rxs_pkg;

   // Receive status flags, also used for the armed-clear bits
   typedef struct packed {
      logic full;
      logic ovr;
   } rxs_flags_t;

   localparam rxs_flags_t RXS_FLAGS_CLR = '{full: 1'b0, ovr: 1'b0};

endpackage

// File: rtl/spi_rxs_flags.sv
module spi_rxs_flags
   import spi_rxs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       strobe_i,
   input  logic       rd_stat_i,
   input  logic       rd_data_i,
   output logic       load_o,
   output rxs_flags_t flags_o
);

   rxs_flags_t flags_q, flags_d;
   rxs_flags_t arm_q, arm_d;
   logic       full_kept, ovr_kept;

   // Clears take effect first; a strobe in the same cycle is seen after them
   always_comb begin
      full_kept = flags_q.full & ~(rd_data_i & arm_q.full);
      ovr_kept  = flags_q.ovr  & ~(rd_data_i & arm_q.ovr);
      load_o    = strobe_i & ~ovr_kept & ~full_kept;
      flags_d.full = full_kept | load_o;
      flags_d.ovr  = ovr_kept | (strobe_i & ~ovr_kept & full_kept);
   end

   // Status read snapshots the flags; a data read consumes the snapshot
   always_comb begin
      if (rd_stat_i)      arm_d = flags_q;
      else if (rd_data_i) arm_d = RXS_FLAGS_CLR;
      else                arm_d = arm_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= RXS_FLAGS_CLR;
         arm_q   <= RXS_FLAGS_CLR;
      end else begin
         flags_q <= flags_d;
         arm_q   <= arm_d;
      end
   end

   assign flags_o = flags_q;

   a_r2_full_sets: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_i && !flags_q.full && !flags_q.ovr |=> flags_q.full);

   a_r3_ovr_on_full: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_i && flags_q.full && !flags_q.ovr && !rd_data_i |=> flags_q.ovr);

   a_r4_full_held: assert property (@(posedge clk) disable iff (!rst_n)
      flags_q.full && !(rd_data_i && arm_q.full) |=> flags_q.full);

   a_r6_ovr_held: assert property (@(posedge clk) disable iff (!rst_n)
      flags_q.ovr && !(rd_data_i && arm_q.ovr) |=> flags_q.ovr);

   a_r5_ovr_clears: assert property (@(posedge clk) disable iff (!rst_n)
      flags_q.ovr && rd_data_i && arm_q.ovr && !rd_stat_i |=> !flags_q.ovr);

   a_r8_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_i && rd_data_i && arm_q.full && flags_q.full
      && !(flags_q.ovr && !arm_q.ovr) |=> flags_q.full && !flags_q.ovr);

endmodule

// File: rtl/spi_rxs_datareg.sv
module spi_rxs_datareg #(
   parameter int                DATA_W   = 8,
   parameter logic [DATA_W-1:0] RST_DATA = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] din_i,
   output logic [DATA_W-1:0] dout_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dout_o <= RST_DATA;
      else if (load_i) dout_o <= din_i;
   end

endmodule

// File: rtl/spi_rxs_irq.sv
module spi_rxs_irq
   import spi_rxs_pkg::*;
#(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  rxs_flags_t flags_i,
   input  logic       rx_ie_i,
   input  logic       err_ie_i,
   output logic       rx_irq_o,
   output logic       err_irq_o
);

   logic rx_req, err_req;

   assign rx_req  = flags_i.full & rx_ie_i;
   assign err_req = flags_i.ovr  & err_ie_i;

   generate
      if (IRQ_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rx_irq_o  <= 1'b0;
               err_irq_o <= 1'b0;
            end else begin
               rx_irq_o  <= rx_req;
               err_irq_o <= err_req;
            end
         end
      end else begin : g_comb
         assign rx_irq_o  = rx_req;
         assign err_irq_o = err_req;

         a_r9_rx_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
            rx_irq_o |-> flags_i.full && rx_ie_i);

         a_r9_err_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
            err_irq_o |-> flags_i.ovr && err_ie_i);
      end
   endgenerate

endmodule

// File: rtl/spi_rx_status.sv
module spi_rx_status
   import spi_rxs_pkg::*;
#(
   parameter int                DATA_W   = 8,
   parameter logic [DATA_W-1:0] RST_DATA = '0,
   parameter bit                IRQ_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_strobe_i,
   input  logic [DATA_W-1:0] rx_byte_i,
   input  logic              rd_stat_i,
   input  logic              rd_data_i,
   input  logic              rx_ie_i,
   input  logic              err_ie_i,
   output logic              rx_full_o,
   output logic              ovr_o,
   output logic [DATA_W-1:0] data_o,
   output logic              rx_irq_o,
   output logic              err_irq_o
);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("spi_rx_status: DATA_W must be at least 1");
      end
   endgenerate

   rxs_flags_t flags;
   logic       load;

   spi_rxs_flags u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .strobe_i  (rx_strobe_i),
      .rd_stat_i (rd_stat_i),
      .rd_data_i (rd_data_i),
      .load_o    (load),
      .flags_o   (flags)
   );

   spi_rxs_datareg #(
      .DATA_W   (DATA_W),
      .RST_DATA (RST_DATA)
   ) u_data (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .din_i  (rx_byte_i),
      .dout_o (data_o)
   );

   spi_rxs_irq #(
      .IRQ_REG (IRQ_REG)
   ) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .flags_i   (flags),
      .rx_ie_i   (rx_ie_i),
      .err_ie_i  (err_ie_i),
      .rx_irq_o  (rx_irq_o),
      .err_irq_o (err_irq_o)
   );

   assign rx_full_o = flags.full;
   assign ovr_o     = flags.ovr;

   a_r7_drop_while_ovr: assert property (@(posedge clk) disable iff (!rst_n)
      rx_strobe_i && ovr_o && !rd_data_i |=> $stable(data_o) && !$rose(rx_full_o));

   a_r3_keep_old_data: assert property (@(posedge clk) disable iff (!rst_n)
      rx_strobe_i && rx_full_o && !rd_data_i |=> $stable(data_o));

   a_r2_load_byte: assert property (@(posedge clk) disable iff (!rst_n)
      rx_strobe_i && !rx_full_o && !ovr_o |=> data_o == $past(rx_byte_i));

endmodule

// File: tb/spi_rx_status_test.sv
module spi_rx_status_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       strobe = 1'b0, rs = 1'b0, rd = 1'b0, rxie = 1'b0, errie = 1'b0;
   logic [7:0] byte_in = 8'h00;
   logic       full, ovr, rxirq, errirq;
   logic [7:0] data;

   int n_run = 0, n_fail = 0;
   int cyc = 0;
   bit done = 1'b0;

   // reference model state
   bit       m_full, m_ovr, m_af, m_ao;
   bit [7:0] m_data;

   always #2.5 clk = ~clk;

   spi_rx_status uut (
      .clk(clk), .rst_n(rst_n), .rx_strobe_i(strobe), .rx_byte_i(byte_in),
      .rd_stat_i(rs), .rd_data_i(rd), .rx_ie_i(rxie), .err_ie_i(errie),
      .rx_full_o(full), .ovr_o(ovr), .data_o(data),
      .rx_irq_o(rxirq), .err_irq_o(errirq)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic void model_edge(bit s, bit [7:0] b, bit st, bit dr);
      bit fk, ok;
      fk = m_full & ~(dr & m_af);
      ok = m_ovr & ~(dr & m_ao);
      if (st) begin m_af = m_full; m_ao = m_ovr; end
      else if (dr) begin m_af = 0; m_ao = 0; end
      if (s && !ok && !fk) begin m_data = b; fk = 1; end
      else if (s && !ok && fk) ok = 1;
      m_full = fk;
      m_ovr  = ok;
   endfunction

   // called at a falling edge; result is observable at the next falling edge
   task automatic step(bit s, bit [7:0] b, bit st, bit dr);
      strobe = s; byte_in = b; rs = st; rd = dr;
      @(posedge clk);
      model_edge(s, b, st, dr);
      @(negedge clk);
      strobe = 0; rs = 0; rd = 0;
   endtask

   task automatic chk_model();
      chk("R2 data", data, m_data);
      chk("R4 full", full, m_full);
      chk("R5 ovr", ovr, m_ovr);
      chk("R9 rxirq", rxirq, m_full & rxie);
      chk("R9 errirq", errirq, m_ovr & errie);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 full", full, 0);
      chk("R1 ovr", ovr, 0);
      chk("R1 data", data, 0);
      chk("R1 rxirq", rxirq, 0);
      chk("R1 errirq", errirq, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 load
      step(1, 8'hA5, 0, 0);
      chk("R2 full", full, 1); chk("R2 data", data, 8'hA5);
      // R4 data read without armed status read
      step(0, 0, 0, 1);
      chk("R4 unarmed", full, 1);
      step(0, 0, 1, 0);
      chk("R4 stat only", full, 1);
      step(0, 0, 0, 1);
      chk("R4 cleared", full, 0); chk("R4 data kept", data, 8'hA5);

      // overrun window sequence
      step(1, 8'h11, 0, 0);
      step(0, 0, 1, 0);
      step(1, 8'h22, 0, 0);
      chk("R3 ovr", ovr, 1); chk("R3 data", data, 8'h11);
      step(0, 0, 0, 1);
      chk("R6 full cleared", full, 0); chk("R6 ovr kept", ovr, 1);
      step(1, 8'h44, 0, 0);
      chk("R7 full", full, 0); chk("R7 data", data, 8'h11);
      step(0, 0, 1, 0);
      step(0, 0, 0, 1);
      chk("R5 ovr cleared", ovr, 0);

      // R8 same-cycle strobe with clearing read
      step(1, 8'h55, 0, 0);
      step(0, 0, 1, 0);
      step(1, 8'h66, 0, 1);
      chk("R8 full", full, 1); chk("R8 data", data, 8'h66); chk("R8 ovr", ovr, 0);

      // R9 interrupts
      rxie = 1; errie = 0;
      #1 chk("R9 rxirq on", rxirq, 1); chk("R9 errirq off", errirq, 0);
      step(1, 8'h77, 0, 0);
      errie = 1;
      #1 chk("R9 errirq on", errirq, 1);
      rxie = 0;
      #1 chk("R9 rxirq masked", rxirq, 0);
      @(negedge clk);
      chk_model();

      // constrained random traffic
      void'($urandom(32'd2024));
      for (int i = 0; i < 4000; i++) begin
         if (($urandom % 64) == 0) rxie = $urandom % 2;
         if (($urandom % 64) == 0) errie = $urandom % 2;
         step(($urandom % 10) < 3, 8'($urandom), ($urandom % 4) == 0, ($urandom % 4) == 0);
         chk_model();
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule